// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Threshold Unit

This block keeps the two threshold offsets used to raise early-warning flags on a FIFO and drives those flags from an occupancy count supplied by the FIFO core. The almost-empty offset is measured in words above an empty FIFO. The almost-full offset is measured in words of free space below a full FIFO. Both flags are active-low and registered.

The level of the load strap, sampled while master reset is held, does two things. It picks the default thresholds (127 or 1023 words). It also fixes, until the next master reset, the only way software may rewrite the offsets: a serial bit stream, or one word per offset on a parallel bus. With the load pin low after reset, the offsets can be written by the selected method and read back over the parallel output bus in either mode. The FIFO storage and its pointers sit outside this block.

Top module: `afo_offset_ctrl`

## Requirements
- R1: A clock edge with `mrst_n` low and `ld_n` low sets both offsets to 127 and selects the parallel write method. The same edge clears `rd_data`, drives `ae_n` low and drives `af_n` high.
- R2: A clock edge with `mrst_n` low and `ld_n` high sets both offsets to 1023 and selects the serial write method. The method cannot change until the next master reset.
- R3: In serial method, each edge with `ld_n` and `sen_n` both low writes `si` into the next offset bit. The order is almost-empty bits 0 to OFS_W-1, then almost-full bits 0 to OFS_W-1, then back to almost-empty bit 0. The bit position restarts at almost-empty bit 0 on any edge with `ld_n` high.
- R4: In serial method, `wr_n` has no effect, and an edge with `sen_n` high leaves both offsets unchanged.
- R5: In parallel method, each edge with `ld_n` and `wr_n` both low writes `wr_data` into the almost-empty offset, then into the almost-full offset, alternating. The order restarts at almost-empty on any edge with `ld_n` high. `sen_n` and `si` have no effect in this method.
- R6: In both methods, each edge with `ld_n` and `rd_n` both low loads `rd_data` with the almost-empty offset, then with the almost-full offset, alternating. The order restarts at almost-empty on any edge with `ld_n` high. On every other edge `rd_data` holds its value.
- R7: After each edge, `ae_n` is 0 if `occ` was at or below the almost-empty offset at that edge, and 1 otherwise.
- R8: After each edge, `af_n` is 0 if DEPTH minus `occ` was at or below the almost-full offset at that edge, and 1 otherwise.
- R9: A readback and a parallel write of the same offset on the same edge return the value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| mrst_n | input | 1 | Synchronous master reset, active low |
| ld_n | input | 1 | Strap during reset; programming access enable after reset, active low |
| sen_n | input | 1 | Serial shift enable, active low |
| si | input | 1 | Serial offset data |
| wr_n | input | 1 | Parallel offset write strobe, active low |
| rd_n | input | 1 | Parallel offset read strobe, active low |
| wr_data | input | OFS_W | Parallel offset write data |
| occ | input | CNT_W | Words currently held by the FIFO, 0 to DEPTH |
| rd_data | output | OFS_W | Offset readback |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
The assertions assume that `occ` never exceeds DEPTH, because free space is computed as DEPTH minus `occ`. They also assume that the strap level on `ld_n` is steady during the last clock edge of master reset. The stimulus keeps `occ` inside 0 to DEPTH, including both ends. It changes `ld_n` only at falling clock edges, and holds it steady for several cycles of reset. Apart from the steps below, the strobes are driven one at a time: the same-edge read and write case is driven on purpose, and `sen_n`/`si` or `wr_n` are toggled in the method that should ignore them.

// File: rtl/afo_pkg.sv
package afo_pkg;

    // write method latched from the load strap at master reset
    typedef enum logic {
        PROG_PAR = 1'b0,
        PROG_SER = 1'b1
    } prog_mode_e;

endpackage

// File: rtl/afo_prog.sv
module afo_prog
    import afo_pkg::*;
#(
    parameter int OFS_W  = 14,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             ld_n,
    input  logic             sen_n,
    input  logic             si,
    input  logic             wr_n,
    input  logic [OFS_W-1:0] wr_data,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs
);

    localparam int SBITS  = 2 * OFS_W;
    localparam int SIDX_W = $clog2(SBITS);

    typedef struct packed {
        prog_mode_e        mode;
        logic [OFS_W-1:0]  ae;
        logic [OFS_W-1:0]  af;
        logic              wsel;
        logic [SIDX_W-1:0] sidx;
    } prog_st_t;

    prog_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_n) begin
            st_d.wsel = 1'b0;
            st_d.sidx = '0;
        end else if (st_q.mode == PROG_SER) begin
            if (!sen_n) begin
                for (int b = 0; b < OFS_W; b++) begin
                    if (int'(st_q.sidx) == b)         st_d.ae[b] = si;
                    if (int'(st_q.sidx) == b + OFS_W) st_d.af[b] = si;
                end
                st_d.sidx = (st_q.sidx == SIDX_W'(SBITS - 1)) ? '0 : st_q.sidx + 1'b1;
            end
        end else if (!wr_n) begin
            if (st_q.wsel) st_d.af = wr_data;
            else           st_d.ae = wr_data;
            st_d.wsel = ~st_q.wsel;
        end
        if (!mrst_n) begin
            st_d.mode = ld_n ? PROG_SER : PROG_PAR;
            st_d.ae   = ld_n ? OFS_W'(DEF_HI) : OFS_W'(DEF_LO);
            st_d.af   = ld_n ? OFS_W'(DEF_HI) : OFS_W'(DEF_LO);
            st_d.wsel = 1'b0;
            st_d.sidx = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ae_ofs = st_q.ae;
    assign af_ofs = st_q.af;

    a_r1_par_defaults: assert property (@(posedge clk) disable iff (!mrst_n)
        ($past(!mrst_n) && !$past(ld_n)) |->
            (st_q.mode == PROG_PAR && st_q.ae == OFS_W'(DEF_LO) && st_q.af == OFS_W'(DEF_LO)));

    a_r2_ser_defaults: assert property (@(posedge clk) disable iff (!mrst_n)
        ($past(!mrst_n) && $past(ld_n)) |->
            (st_q.mode == PROG_SER && st_q.ae == OFS_W'(DEF_HI) && st_q.af == OFS_W'(DEF_HI)));

    a_r2_mode_locked: assert property (@(posedge clk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(st_q.mode));

    a_r4_ser_hold: assert property (@(posedge clk) disable iff (!mrst_n)
        (st_q.mode == PROG_SER && (sen_n || ld_n)) |=> ($stable(st_q.ae) && $stable(st_q.af)));

    a_r5_par_hold: assert property (@(posedge clk) disable iff (!mrst_n)
        (st_q.mode == PROG_PAR && (wr_n || ld_n)) |=> ($stable(st_q.ae) && $stable(st_q.af)));

endmodule

// File: rtl/afo_readback.sv
module afo_readback #(
    parameter int OFS_W = 14
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             ld_n,
    input  logic             rd_n,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic [OFS_W-1:0] rd_data
);

    typedef struct packed {
        logic             rsel;
        logic [OFS_W-1:0] dout;
    } rb_st_t;

    rb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_n) begin
            st_d.rsel = 1'b0;
        end else if (!rd_n) begin
            st_d.dout = st_q.rsel ? af_ofs : ae_ofs;
            st_d.rsel = ~st_q.rsel;
        end
        if (!mrst_n) begin
            st_d.rsel = 1'b0;
            st_d.dout = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_data = st_q.dout;

    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!mrst_n)
        (ld_n || rd_n) |=> $stable(st_q.dout));

endmodule

// File: rtl/afo_flags.sv
module afo_flags #(
    parameter int DEPTH = 16384,
    parameter int CNT_W = 15,
    parameter int OFS_W = 14
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic [CNT_W-1:0] occ,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic             ae_n,
    output logic             af_n
);

    localparam int CMP_W = CNT_W + 1;

    typedef struct packed {
        logic ae_n;
        logic af_n;
    } flg_st_t;

    flg_st_t          st_d, st_q;
    logic [CMP_W-1:0] used_w, free_w;

    always_comb begin
        used_w    = CMP_W'(occ);
        free_w    = CMP_W'(DEPTH) - used_w;
        st_d.ae_n = !(used_w <= CMP_W'(ae_ofs));
        st_d.af_n = !(free_w <= CMP_W'(af_ofs));
        if (!mrst_n) begin
            st_d.ae_n = 1'b0;
            st_d.af_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ae_n = st_q.ae_n;
    assign af_n = st_q.af_n;

    a_r7_empty_low: assert property (@(posedge clk) disable iff (!mrst_n)
        (occ == '0) |=> !ae_n);

    a_r8_full_low: assert property (@(posedge clk) disable iff (!mrst_n)
        (occ == CNT_W'(DEPTH)) |=> !af_n);

endmodule

// File: rtl/afo_offset_ctrl.sv
module afo_offset_ctrl #(
    parameter int DEPTH  = 16384,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023,
    parameter int OFS_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             ld_n,
    input  logic             sen_n,
    input  logic             si,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic [OFS_W-1:0] wr_data,
    input  logic [CNT_W-1:0] occ,
    output logic [OFS_W-1:0] rd_data,
    output logic             ae_n,
    output logic             af_n
);

    logic [OFS_W-1:0] ae_ofs, af_ofs;

    afo_prog #(
        .OFS_W (OFS_W),
        .DEF_LO(DEF_LO),
        .DEF_HI(DEF_HI)
    ) i_prog (
        .clk    (clk),
        .mrst_n (mrst_n),
        .ld_n   (ld_n),
        .sen_n  (sen_n),
        .si     (si),
        .wr_n   (wr_n),
        .wr_data(wr_data),
        .ae_ofs (ae_ofs),
        .af_ofs (af_ofs)
    );

    afo_readback #(
        .OFS_W(OFS_W)
    ) i_readback (
        .clk    (clk),
        .mrst_n (mrst_n),
        .ld_n   (ld_n),
        .rd_n   (rd_n),
        .ae_ofs (ae_ofs),
        .af_ofs (af_ofs),
        .rd_data(rd_data)
    );

    afo_flags #(
        .DEPTH(DEPTH),
        .CNT_W(CNT_W),
        .OFS_W(OFS_W)
    ) i_flags (
        .clk   (clk),
        .mrst_n(mrst_n),
        .occ   (occ),
        .ae_ofs(ae_ofs),
        .af_ofs(af_ofs),
        .ae_n  (ae_n),
        .af_n  (af_n)
    );

endmodule

// File: tb/test_afo_offset_ctrl.sv
module test_afo_offset_ctrl;

    localparam int DEPTH = 16384;
    localparam int W     = 14;
    localparam int CW    = 15;

    logic          clk = 1'b0;
    logic          mrst_n = 1'b0;
    logic          ld_n = 1'b0;
    logic          sen_n = 1'b1;
    logic          si = 1'b0;
    logic          wr_n = 1'b1;
    logic          rd_n = 1'b1;
    logic [W-1:0]  wr_data = '0;
    logic [CW-1:0] occ = '0;
    logic [W-1:0]  rd_data;
    logic          ae_n, af_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    afo_offset_ctrl i_afo_offset_ctrl (
        .clk(clk), .mrst_n(mrst_n), .ld_n(ld_n), .sen_n(sen_n), .si(si),
        .wr_n(wr_n), .rd_n(rd_n), .wr_data(wr_data), .occ(occ),
        .rd_data(rd_data), .ae_n(ae_n), .af_n(af_n)
    );

    // behavioural reference, written from the requirements
    int m_ae, m_af, m_ser, m_wsel, m_sidx, m_rsel, m_dout, m_aen, m_afn;
    bit m_init = 0;

    always @(posedge clk) begin
        if (!mrst_n) begin
            m_init = 1;
            m_ser  = ld_n ? 1 : 0;
            m_ae   = ld_n ? 1023 : 127;
            m_af   = m_ae;
            m_wsel = 0; m_sidx = 0; m_rsel = 0;
            m_dout = 0; m_aen = 0; m_afn = 1;
        end else begin
            m_aen = (int'(occ) <= m_ae) ? 0 : 1;
            m_afn = ((DEPTH - int'(occ)) <= m_af) ? 0 : 1;
            if (ld_n) m_rsel = 0;
            else if (!rd_n) begin
                m_dout = m_rsel ? m_af : m_ae;
                m_rsel = 1 - m_rsel;
            end
            if (ld_n) begin
                m_wsel = 0; m_sidx = 0;
            end else if (m_ser == 1) begin
                if (!sen_n) begin
                    if (m_sidx < W) m_ae = (m_ae & ~(1 << m_sidx)) | (int'(si) << m_sidx);
                    else m_af = (m_af & ~(1 << (m_sidx - W))) | (int'(si) << (m_sidx - W));
                    m_sidx = (m_sidx + 1) % (2 * W);
                end
            end else if (!wr_n) begin
                if (m_wsel == 1) m_af = int'(wr_data);
                else             m_ae = int'(wr_data);
                m_wsel = 1 - m_wsel;
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // per-cycle comparison against the model (outputs settle at posedge)
    always @(negedge clk) begin
        if (m_init && !done) begin
            chk("R6 rd_data vs model", int'(rd_data), m_dout);
            chk("R7 ae_n vs model", int'(ae_n), m_aen);
            chk("R8 af_n vs model", int'(af_n), m_afn);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic strap);
        mrst_n = 1'b0; ld_n = strap; sen_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        repeat (3) tick();
        mrst_n = 1'b1; ld_n = 1'b1;
        tick();
    endtask

    task automatic read_pair(output int a, output int b);
        ld_n = 1'b0; rd_n = 1'b0;
        tick(); a = int'(rd_data);
        tick(); b = int'(rd_data);
        rd_n = 1'b1; ld_n = 1'b1;
        tick();
    endtask

    task automatic par_write(input int a, input int b);
        ld_n = 1'b0; wr_n = 1'b0;
        wr_data = W'(a); tick();
        wr_data = W'(b); tick();
        wr_n = 1'b1; ld_n = 1'b1;
        tick();
    endtask

    task automatic ser_write(input int a, input int b);
        logic [2*W-1:0] v;
        v = {W'(b), W'(a)};
        ld_n = 1'b0; sen_n = 1'b0;
        for (int i = 0; i < 2 * W; i++) begin
            si = v[i]; tick();
        end
        sen_n = 1'b1; ld_n = 1'b1;
        tick();
    endtask

    initial begin
        int a, b;
        // R1: parallel strap
        do_reset(1'b0);
        chk("R1 reset rd_data", int'(rd_data), 0);
        chk("R1 reset ae_n", int'(ae_n), 0);
        chk("R1 reset af_n", int'(af_n), 1);
        read_pair(a, b);
        chk("R1 default ae offset", a, 127);
        chk("R1 default af offset", b, 127);

        // R5: parallel writes, serial pins ignored
        par_write(300, 50);
        read_pair(a, b);
        chk("R5 par ae write", a, 300);
        chk("R5 par af write", b, 50);
        ld_n = 1'b0; sen_n = 1'b0;
        for (int i = 0; i < 2 * W; i++) begin si = 1'b1; tick(); end
        sen_n = 1'b1; ld_n = 1'b1; tick();
        read_pair(a, b);
        chk("R5 serial ignored ae", a, 300);
        chk("R5 serial ignored af", b, 50);

        // R7/R8 boundaries with ae=300, af=50
        occ = CW'(300); tick(); tick();
        chk("R7 occ at ae offset", int'(ae_n), 0);
        occ = CW'(301); tick(); tick();
        chk("R7 occ above ae offset", int'(ae_n), 1);
        occ = CW'(DEPTH - 50); tick(); tick();
        chk("R8 free at af offset", int'(af_n), 0);
        occ = CW'(DEPTH - 51); tick(); tick();
        chk("R8 free above af offset", int'(af_n), 1);
        occ = CW'(DEPTH); tick(); tick();
        chk("R8 full", int'(af_n), 0);
        occ = '0; tick(); tick();
        chk("R7 empty", int'(ae_n), 0);

        // R9: read and write of ae on the same edge
        ld_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; wr_data = W'(777);
        tick();
        chk("R9 same-edge read returns old", int'(rd_data), 300);
        rd_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1; tick();
        read_pair(a, b);
        chk("R9 write landed", a, 777);

        // R2: serial strap
        do_reset(1'b1);
        read_pair(a, b);
        chk("R2 default ae offset", a, 1023);
        chk("R2 default af offset", b, 1023);

        // R3: serial shift order
        ser_write(5, 8192);
        read_pair(a, b);
        chk("R3 serial ae", a, 5);
        chk("R3 serial af", b, 8192);

        // R4: sen_n high and wr_n ignored in serial method
        ld_n = 1'b0; sen_n = 1'b1;
        for (int i = 0; i < 6; i++) begin si = ~si; tick(); end
        wr_n = 1'b0; wr_data = W'(11); tick(); tick();
        wr_n = 1'b1; ld_n = 1'b1; tick();
        read_pair(a, b);
        chk("R4 serial hold ae", a, 5);
        chk("R4 serial hold af", b, 8192);

        // R2: mode locked; R3 partial stream restarts after ld_n high
        ld_n = 1'b0; sen_n = 1'b0; si = 1'b0;
        repeat (3) tick();
        sen_n = 1'b1; ld_n = 1'b1; tick();
        ser_write(1000, 40);
        read_pair(a, b);
        chk("R3 restart ae", a, 1000);
        chk("R2 still serial af", b, 40);

        // flag sweep compared against the model each cycle
        for (int o = 0; o <= DEPTH; o += 997) begin occ = CW'(o); tick(); end
        occ = CW'(DEPTH); tick(); tick();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule